// File: doc/BRIEF.md
# Pulse-Position Frame Header Transmitter

This block sits between an Ethernet MAC and a phone-line symbol encoder. The MAC delivers a frame as a byte stream. The block accepts the first eight octets of each frame and throws them away; these are the preamble and the start delimiter. In their place it drives a header onto a single-bit line output. That header is a train of carrier bursts, and every header bit is carried by where a burst starts relative to the start of the burst before it. Once the header is finished, the remaining frame bytes, CRC included, pass unchanged to the downstream encoder over a valid/ready stream.

The header has four parts, sent in this order:
- a synchronisation pair: two bursts a programmable distance apart;
- an access field: a 12-bit word made of the control word above the access ID, sent as six 2-bit symbols;
- a programmable silence;
- a 32-bit PHY-communication word, sent as sixteen 2-bit symbols.

Every burst is four square-wave cycles at a programmable half-period. All distances are counted in reference-clock cycles. The access-symbol spacing depends only on the programmed offset and slot values, never on the payload rate.

Top module: `ppm_hdr_tx`

## Requirements
- R1: After reset, and between frames, `busy_o`, `line_o` and `m_valid` are 0 and `s_ready` is 1.
- R2: The first 8 bytes accepted on the input stream of each frame are consumed and never appear on the output stream.
- R3: Input bytes 8 onward are forwarded in order, with their values and the `last` marker unchanged. `m_valid` stays 0 until the last header burst has ended.
- R4: The header holds exactly 24 bursts. Burst 0 starts (`line_o` rises) one cycle after the first byte of a frame is accepted. Burst 1 starts `cfg_sync_gap` cycles after burst 0.
- R5: Bursts 2..7 carry the 12-bit word {cfg_ctl, cfg_aid}. Burst 2+i carries the bit pair [2i+1:2i], so bit 0 is sent first. The pair value v gives a start distance of `cfg_min_off + v*cfg_slot` from the previous burst.
- R6: Burst 8 starts `cfg_silence + cfg_min_off + v*cfg_slot` cycles after burst 7, where v is bits [1:0] of the PHY word.
- R7: Bursts 8..23 carry `cfg_phy_word` pair [2i+1:2i] in burst 8+i. Bursts 9..23 use the spacing rule of R5.
- R8: Each burst is four square-wave cycles. Each cycle is high for `cfg_half_per` cycles and then low for `cfg_half_per` cycles, so successive rising edges within a burst are 2*`cfg_half_per` apart. `line_o` is 0 outside bursts.
- R9: `busy_o` rises on the cycle after the first byte is accepted. It falls on the cycle after the `last` byte is taken by the downstream side. While forwarding, `s_ready` follows `m_ready`.
- R10: All `cfg_*` inputs are sampled when the first byte of a frame is accepted. Later changes have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_aid | input | 8 | Access ID, low part of the access field |
| cfg_ctl | input | 4 | Control word, high part of the access field |
| cfg_phy_word | input | 32 | PHY-communication word |
| cfg_half_per | input | 8 | Carrier half-period in clock cycles (at least 1) |
| cfg_sync_gap | input | 16 | Distance from burst 0 to burst 1 |
| cfg_min_off | input | 16 | Minimum symbol distance |
| cfg_slot | input | 16 | Distance between adjacent symbol positions |
| cfg_silence | input | 16 | Extra distance before the first PHY-word burst |
| s_valid | input | 1 | MAC byte valid |
| s_data | input | 8 | MAC byte |
| s_last | input | 1 | Marks the last MAC byte of a frame |
| s_ready | output | 1 | Block accepts the MAC byte |
| m_valid | output | 1 | Payload byte valid towards the encoder |
| m_data | output | 8 | Payload byte |
| m_last | output | 1 | Marks the last payload byte |
| m_ready | input | 1 | Encoder accepts the payload byte |
| line_o | output | 1 | Carrier burst output |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-bit access ID, a 4-bit control word, a 32-bit PHY word, 16-bit distance counters and four carrier cycles per burst. The carrier half-period is a run-time input, so one build covers several burst shapes. With half-periods of 1 and 3 and distances of a few tens of cycles, a whole header lasts a few hundred cycles. That keeps every symbol value (0 through 3), the least-significant-pair-first ordering, the silence step and stalls on the output side within a short run. The checks measure the distance between burst rising edges on `line_o` and compare it with distances computed from the configuration.

// File: rtl/ppm_hdr_pkg.sv
// ppm_hdr_pkg: shared defaults and the state type of the frame gate.
// Assumes: nothing; it holds declarations only.
package ppm_hdr_pkg;

    // Default field sizes of the header.
    localparam int DEF_AID_W  = 8;
    localparam int DEF_CTL_W  = 4;
    localparam int DEF_PHY_W  = 32;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_HALF_W = 8;
    localparam int DEF_NCARR  = 4;
    localparam int DEF_DROP   = 8;

    // Phase of the frame gate.
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_HDR  = 2'd1,
        GATE_PASS = 2'd2
    } gate_st_e;

endpackage

// File: rtl/ppm_hdr_sched.sv
// ppm_hdr_sched: decides when each of the header bursts starts.
// The frame-start pulse fires burst 0. It also latches the configuration and
// the symbol word, which is the access field with the PHY word above it.
// Each later burst fires once a distance counter expires. The distance is
// taken from the symbol pair at the bottom of the word, and the word then
// shifts down by one pair.
// Assumes: start_i only while idle, every distance >= 1, and half-period >= 1.
module ppm_hdr_sched #(
    parameter int ACC_W  = 12,
    parameter int PHY_W  = 32,
    parameter int CNT_W  = 16,
    parameter int HALF_W = 8,
    parameter int NCARR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic [CNT_W-1:0]  sync_gap_i,
    input  logic [CNT_W-1:0]  min_off_i,
    input  logic [CNT_W-1:0]  slot_i,
    input  logic [CNT_W-1:0]  silence_i,
    output logic              fire_o,
    output logic [HALF_W-1:0] half_o,
    output logic              active_o
);
    localparam int NACC   = ACC_W / 2;
    localparam int NPHY   = PHY_W / 2;
    localparam int NPULSE = 2 + NACC + NPHY;
    localparam int IDX_W  = $clog2(NPULSE + 1);
    localparam int SR_W   = ACC_W + PHY_W;

    logic              active_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  fire_idx;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  gap;
    logic [CNT_W-1:0]  sym_term;
    logic [CNT_W-1:0]  plen_q;
    logic [CNT_W-1:0]  min_q;
    logic [CNT_W-1:0]  slot_q;
    logic [CNT_W-1:0]  sil_q;
    logic [SR_W-1:0]   sr_q;
    logic [HALF_W-1:0] half_q;
    logic              fire;

    // Fire now: on frame start, or when the counter of an armed burst expires.
    always_comb begin
        fire = start_i | (active_q && (cnt_q == '0) && (idx_q < IDX_W'(NPULSE)));
    end

    // Index of the burst that fires this cycle.
    always_comb begin
        fire_idx = start_i ? '0 : idx_q;
    end

    // Distance from this burst to the next one.
    always_comb begin
        sym_term = min_q + CNT_W'(sr_q[1:0]) * slot_q;
        if (fire_idx == '0) begin
            gap = sync_gap_i;
        end else if (fire_idx == IDX_W'(NACC + 1)) begin
            gap = sil_q + sym_term;
        end else if (fire_idx == IDX_W'(NPULSE - 1)) begin
            gap = plen_q;
        end else begin
            gap = sym_term;
        end
    end

    // Configuration latch, pulse index, distance counter and symbol shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            cnt_q    <= '0;
            sr_q     <= '0;
            plen_q   <= '0;
            min_q    <= '0;
            slot_q   <= '0;
            sil_q    <= '0;
            half_q   <= '0;
        end else begin
            if (start_i) begin
                sr_q   <= {phy_i, acc_i};
                min_q  <= min_off_i;
                slot_q <= slot_i;
                sil_q  <= silence_i;
                half_q <= half_i;
                plen_q <= CNT_W'(2 * NCARR) * CNT_W'(half_i);
            end
            if (fire) begin
                active_q <= 1'b1;
                idx_q    <= fire_idx + 1'b1;
                cnt_q    <= gap - 1'b1;
                if (!start_i && (fire_idx != IDX_W'(NPULSE - 1))) begin
                    sr_q <= sr_q >> 2;
                end
            end else if (active_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (idx_q == IDX_W'(NPULSE)) begin
                    active_q <= 1'b0;
                end
            end
        end
    end

    assign fire_o   = fire;
    assign half_o   = start_i ? half_i : half_q;
    assign active_o = active_q;

endmodule

// File: rtl/ppm_burst_gen.sv
// ppm_burst_gen: turns one fire pulse into a burst of NCARR square-wave cycles.
// Each cycle is high for half_i clocks and then low for half_i clocks. The
// output is registered, so the burst begins on the cycle after the fire pulse.
// A new fire pulse restarts the burst.
// Assumes: half_i >= 1.
module ppm_burst_gen #(
    parameter int HALF_W = 8,
    parameter int NCARR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              line_o
);
    localparam int NHALF = 2 * NCARR;
    localparam int PH_W  = $clog2(NHALF);

    logic              run_q;
    logic              line_q;
    logic [PH_W-1:0]   ph_q;
    logic [HALF_W-1:0] hcnt_q;
    logic [HALF_W-1:0] half_q;

    // Half-period counter and square-wave phase stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            line_q <= 1'b0;
            ph_q   <= '0;
            hcnt_q <= '0;
            half_q <= '0;
        end else if (fire_i) begin
            run_q  <= 1'b1;
            line_q <= 1'b1;
            ph_q   <= '0;
            hcnt_q <= half_i - 1'b1;
            half_q <= half_i;
        end else if (run_q) begin
            if (hcnt_q != '0) begin
                hcnt_q <= hcnt_q - 1'b1;
            end else if (ph_q == PH_W'(NHALF - 1)) begin
                run_q  <= 1'b0;
                line_q <= 1'b0;
            end else begin
                ph_q   <= ph_q + 1'b1;
                line_q <= ~line_q;
                hcnt_q <= half_q - 1'b1;
            end
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/ppm_byte_gate.sv
// ppm_byte_gate: frame-level control of the byte stream.
// Accepting the first byte of a frame starts the header. The first DROP bytes
// are consumed while the header runs. After both the drops and the header are
// complete, the input passes straight through to the output until the byte
// marked last is taken.
// Assumes: every frame is longer than DROP bytes.
module ppm_byte_gate
    import ppm_hdr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DROP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              m_valid_o,
    output logic [DATA_W-1:0] m_data_o,
    output logic              m_last_o,
    input  logic              m_ready_i,
    input  logic              hdr_active_i,
    output logic              start_o,
    output logic              busy_o
);
    localparam int DC_W = $clog2(DROP + 1);

    gate_st_e          st_q;
    logic [DC_W-1:0]   drop_q;

    // Input acceptance in each phase.
    always_comb begin
        s_ready_o = 1'b0;
        unique case (st_q)
            GATE_IDLE: s_ready_o = 1'b1;
            GATE_HDR:  s_ready_o = (drop_q < DC_W'(DROP));
            GATE_PASS: s_ready_o = m_ready_i;
            default:   s_ready_o = 1'b0;
        endcase
    end

    // Pass-through and control strobes.
    always_comb begin
        m_valid_o = (st_q == GATE_PASS) && s_valid_i;
        m_data_o  = s_data_i;
        m_last_o  = s_last_i;
        start_o   = (st_q == GATE_IDLE) && s_valid_i;
        busy_o    = (st_q != GATE_IDLE);
    end

    // Phase sequencing and counting of dropped bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= GATE_IDLE;
            drop_q <= '0;
        end else begin
            unique case (st_q)
                GATE_IDLE: begin
                    if (s_valid_i) begin
                        st_q   <= GATE_HDR;
                        drop_q <= DC_W'(1);
                    end
                end
                GATE_HDR: begin
                    if (s_valid_i && s_ready_o) begin
                        drop_q <= drop_q + 1'b1;
                    end
                    if (!hdr_active_i && (drop_q == DC_W'(DROP))) begin
                        st_q <= GATE_PASS;
                    end
                end
                GATE_PASS: begin
                    if (s_valid_i && m_ready_i && s_last_i) begin
                        st_q   <= GATE_IDLE;
                        drop_q <= '0;
                    end
                end
                default: st_q <= GATE_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ppm_hdr_tx.sv
// ppm_hdr_tx: top level of the pulse-position header transmitter.
// It joins three parts: the byte gate, which drops the leading octets and
// forwards the rest; the scheduler, which times the header bursts; and the
// burst generator, which shapes each burst on line_o.
// Assumes: each frame is longer than DROP bytes, half-period >= 1, and every
// symbol distance is at least one burst length (2*NCARR*half-period).
module ppm_hdr_tx
    import ppm_hdr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AID_W  = DEF_AID_W,
    parameter int CTL_W  = DEF_CTL_W,
    parameter int PHY_W  = DEF_PHY_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int HALF_W = DEF_HALF_W,
    parameter int NCARR  = DEF_NCARR,
    parameter int DROP   = DEF_DROP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AID_W-1:0]  cfg_aid,
    input  logic [CTL_W-1:0]  cfg_ctl,
    input  logic [PHY_W-1:0]  cfg_phy_word,
    input  logic [HALF_W-1:0] cfg_half_per,
    input  logic [CNT_W-1:0]  cfg_sync_gap,
    input  logic [CNT_W-1:0]  cfg_min_off,
    input  logic [CNT_W-1:0]  cfg_slot,
    input  logic [CNT_W-1:0]  cfg_silence,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    input  logic              m_ready,
    output logic              line_o,
    output logic              busy_o
);
    localparam int ACC_W = AID_W + CTL_W;

    logic              start;
    logic              fire;
    logic              hdr_active;
    logic [HALF_W-1:0] half;

    ppm_byte_gate #(
        .DATA_W(DATA_W),
        .DROP  (DROP)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_valid_i   (s_valid),
        .s_data_i    (s_data),
        .s_last_i    (s_last),
        .s_ready_o   (s_ready),
        .m_valid_o   (m_valid),
        .m_data_o    (m_data),
        .m_last_o    (m_last),
        .m_ready_i   (m_ready),
        .hdr_active_i(hdr_active),
        .start_o     (start),
        .busy_o      (busy_o)
    );

    ppm_hdr_sched #(
        .ACC_W (ACC_W),
        .PHY_W (PHY_W),
        .CNT_W (CNT_W),
        .HALF_W(HALF_W),
        .NCARR (NCARR)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .acc_i     ({cfg_ctl, cfg_aid}),
        .phy_i     (cfg_phy_word),
        .half_i    (cfg_half_per),
        .sync_gap_i(cfg_sync_gap),
        .min_off_i (cfg_min_off),
        .slot_i    (cfg_slot),
        .silence_i (cfg_silence),
        .fire_o    (fire),
        .half_o    (half),
        .active_o  (hdr_active)
    );

    ppm_burst_gen #(
        .HALF_W(HALF_W),
        .NCARR (NCARR)
    ) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(fire),
        .half_i(half),
        .line_o(line_o)
    );

endmodule

// File: rtl/ppm_hdr_tx_chk.sv
// ppm_hdr_tx_chk: port-level properties of the header transmitter, bound to
// every instance of the top module.
// Assumes: the same DROP value as the bound instance.
module ppm_hdr_tx_chk #(
    parameter int DATA_W = 8,
    parameter int DROP   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic [DATA_W-1:0] s_data,
    input logic              s_last,
    input logic              s_ready,
    input logic              m_valid,
    input logic [DATA_W-1:0] m_data,
    input logic              m_last,
    input logic              m_ready,
    input logic              line_o,
    input logic              busy_o
);
    localparam int SC_W = $clog2(DROP + 2);

    logic [SC_W-1:0] seen_q;
    logic            hs_in;

    assign hs_in = s_valid && s_ready;

    // Saturating count of input bytes accepted in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (hs_in) begin
            if (!busy_o) begin
                seen_q <= SC_W'(1);
            end else if (seen_q != SC_W'(DROP + 1)) begin
                seen_q <= seen_q + 1'b1;
            end
        end else if (!busy_o) begin
            seen_q <= '0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!m_valid && !line_o));

    assert_drop_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (seen_q >= SC_W'(DROP)));

    assert_no_payload_in_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> !m_valid);

    assert_line_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> busy_o);

    assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(m_valid && m_ready && m_last));

    assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |-> !s_ready);

endmodule

bind ppm_hdr_tx ppm_hdr_tx_chk #(
    .DATA_W(DATA_W),
    .DROP  (DROP)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(s_valid),
    .s_data (s_data),
    .s_last (s_last),
    .s_ready(s_ready),
    .m_valid(m_valid),
    .m_data (m_data),
    .m_last (m_last),
    .m_ready(m_ready),
    .line_o (line_o),
    .busy_o (busy_o)
);

// File: tb/ppm_hdr_tx_tb.sv
// ppm_hdr_tx_tb: directed scenarios, one task per scenario, each checking its
// own results at the ports.
module ppm_hdr_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_aid = '0;
    logic [3:0]  cfg_ctl = '0;
    logic [31:0] cfg_phy_word = '0;
    logic [7:0]  cfg_half_per = 8'd1;
    logic [15:0] cfg_sync_gap = 16'd8;
    logic [15:0] cfg_min_off = 16'd8;
    logic [15:0] cfg_slot = 16'd1;
    logic [15:0] cfg_silence = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        m_valid;
    logic [7:0]  m_data;
    logic        m_last;
    logic        m_ready = 1'b1;
    logic        line_o;
    logic        busy_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_t [0:127];
    int rise_n = 0;
    logic line_prev = 1'b0;
    logic finished = 1'b0;

    ppm_hdr_tx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_aid     (cfg_aid),
        .cfg_ctl     (cfg_ctl),
        .cfg_phy_word(cfg_phy_word),
        .cfg_half_per(cfg_half_per),
        .cfg_sync_gap(cfg_sync_gap),
        .cfg_min_off (cfg_min_off),
        .cfg_slot    (cfg_slot),
        .cfg_silence (cfg_silence),
        .s_valid     (s_valid),
        .s_data      (s_data),
        .s_last      (s_last),
        .s_ready     (s_ready),
        .m_valid     (m_valid),
        .m_data      (m_data),
        .m_last      (m_last),
        .m_ready     (m_ready),
        .line_o      (line_o),
        .busy_o      (busy_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Record the cycle of every rising edge of line_o.
    always @(negedge clk) begin
        if (line_o && !line_prev && rise_n < 128) begin
            rise_t[rise_n] = cyc;
            rise_n = rise_n + 1;
        end
        line_prev = line_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One whole frame: program, send, collect, then compare.
    task automatic t_frame(input logic [7:0] aid, input logic [3:0] ctl,
                           input logic [31:0] phy, input int half, input int sg,
                           input int mo, input int sl, input int sil,
                           input int nb, input bit bp, input bit scramble);
        logic [11:0] acc;
        int exp_gap [1:24];
        int out_d [0:63];
        int out_l [0:63];
        int out_n;
        int t0;
        int tl;
        int fo;
        int bad;
        int busy_before;
        int busy_after;
        bit done;
        acc = {ctl, aid};
        for (int k = 1; k <= 23; k++) begin
            int v;
            v = 0;
            if (k >= 2 && k <= 7) v = int'(acc[2*(k-2) +: 2]);
            if (k >= 8) v = int'(phy[2*(k-8) +: 2]);
            if (k == 1) exp_gap[k] = sg;
            else exp_gap[k] = (k == 8 ? sil : 0) + mo + v * sl;
        end
        @(negedge clk);
        cfg_aid = aid; cfg_ctl = ctl; cfg_phy_word = phy;
        cfg_half_per = 8'(half); cfg_sync_gap = 16'(sg);
        cfg_min_off = 16'(mo); cfg_slot = 16'(sl); cfg_silence = 16'(sil);
        rise_n = 0;
        out_n = 0; t0 = 0; tl = 0; fo = 0; done = 0;
        busy_before = 0; busy_after = 1;
        fork
            begin
                for (int i = 0; i < nb; i++) begin
                    @(negedge clk);
                    if (i == 1 && scramble) begin
                        cfg_aid = ~aid; cfg_ctl = ~ctl; cfg_phy_word = ~phy;
                        cfg_half_per = 8'(half + 1); cfg_sync_gap = 16'(sg + 7);
                        cfg_min_off = 16'(mo + 5); cfg_slot = 16'(sl + 2);
                        cfg_silence = 16'(sil + 9);
                    end
                    s_valid = 1'b1; s_data = 8'(8'h3C + i); s_last = (i == nb - 1);
                    #1;
                    while (!s_ready) begin
                        @(negedge clk);
                        #1;
                    end
                    if (i == 0) t0 = cyc;
                    if (i == nb - 1) begin
                        tl = cyc;
                        busy_before = int'(busy_o);
                    end
                end
                @(negedge clk);
                s_valid = 1'b0; s_last = 1'b0;
                #3;
                busy_after = int'(busy_o);
            end
            begin
                while (!done) begin
                    @(negedge clk);
                    m_ready = bp ? (cyc % 3 != 0) : 1'b1;
                    #2;
                    if (m_valid && m_ready && out_n < 64) begin
                        if (out_n == 0) fo = cyc;
                        out_d[out_n] = int'(m_data);
                        out_l[out_n] = int'(m_last);
                        out_n++;
                        if (m_last) done = 1;
                    end
                end
            end
        join
        m_ready = 1'b1;
        repeat (3) @(negedge clk);

        // R4: burst count, first burst timing and sync distance
        chk("R4 burst edge count", rise_n, 4 * 24);
        chk("R4 first burst start", rise_t[0], t0 + 1);
        chk("R4 sync distance", rise_t[4] - rise_t[0], exp_gap[1]);
        // R5: access symbols, low pair first
        bad = 0;
        for (int k = 2; k <= 7; k++) begin
            if (rise_t[4*k] - rise_t[4*(k-1)] != exp_gap[k]) begin
                if (bad == 0) chk("R5 access distance", rise_t[4*k] - rise_t[4*(k-1)], exp_gap[k]);
                bad++;
            end
        end
        if (bad == 0) chk("R5 access distances", 0, 0);
        // R6: silence before the first PHY-word burst
        chk("R6 silence distance", rise_t[32] - rise_t[28], exp_gap[8]);
        // R7: PHY-word symbols
        bad = 0;
        for (int k = 9; k <= 23; k++) begin
            if (rise_t[4*k] - rise_t[4*(k-1)] != exp_gap[k]) begin
                if (bad == 0) chk("R7 phy distance", rise_t[4*k] - rise_t[4*(k-1)], exp_gap[k]);
                bad++;
            end
        end
        if (bad == 0) chk("R7 phy distances", 0, 0);
        // R8: carrier edges 2*half apart inside every burst
        bad = 0;
        for (int k = 0; k < 24; k++) begin
            for (int j = 1; j < 4; j++) begin
                if (rise_t[4*k+j] - rise_t[4*k+j-1] != 2 * half) bad++;
            end
        end
        chk("R8 carrier spacing errors", bad, 0);
        // R2/R3: payload contents, count and last marker
        chk("R2 forwarded byte count", out_n, nb - 8);
        bad = 0;
        for (int j = 0; j < out_n; j++) begin
            if (out_d[j] != ((8'h3C + j + 8) & 8'hFF)) bad++;
            if (out_l[j] != ((j == out_n - 1) ? 1 : 0)) bad++;
        end
        chk("R3 payload mismatches", bad, 0);
        chk("R3 payload after header", int'(fo > rise_t[95]), 1);
        // R9: busy held to the last byte, then released
        chk("R9 busy before last", busy_before, 1);
        chk("R9 busy after last", busy_after, 0);
        // R1: quiet again between frames
        chk("R1 idle line", int'(line_o), 0);
        chk("R1 idle busy", int'(busy_o), 0);
        if (tl == 0) chk("R9 last accepted", 0, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset busy", int'(busy_o), 0);
        chk("R1 reset line", int'(line_o), 0);
        chk("R1 reset m_valid", int'(m_valid), 0);
        chk("R1 reset s_ready", int'(s_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // All symbols zero: every distance equals the minimum offset.
    task automatic t_zero_symbols;
        t_frame(8'h00, 4'h0, 32'h0000_0000, 1, 12, 8, 3, 20, 14, 1'b0, 1'b0);
    endtask

    // All symbols three: the farthest slot everywhere.
    task automatic t_max_symbols;
        t_frame(8'hFF, 4'hF, 32'hFFFF_FFFF, 1, 9, 8, 4, 15, 12, 1'b0, 1'b0);
    endtask

    // Pair values 0,1,2,3 in sequence expose the sending order (R5, R7).
    task automatic t_order;
        t_frame(8'hE4, 4'h6, 32'hE41B_936C, 1, 10, 9, 5, 11, 20, 1'b1, 1'b0);
    endtask

    // Longer carrier half-period with a stalling encoder (R8, R9).
    task automatic t_slow_carrier;
        t_frame(8'h5A, 4'h3, 32'h0F0F_A5C3, 3, 30, 26, 6, 4, 24, 1'b1, 1'b0);
    endtask

    // Inputs changed mid-frame must not alter the header (R10).
    task automatic t_cfg_latch_R10;
        t_frame(8'h27, 4'hB, 32'h8421_1248, 1, 14, 10, 2, 6, 16, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_zero_symbols();
        t_max_symbols();
        t_order();
        t_slow_carrier();
        t_cfg_latch_R10();
        t_order();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule